// File: doc/BRIEF.md
# Falling-Edge Tapped Binary Divider

This block is a binary up-counter, 14 stages wide by default, that advances on each high-to-low transition of its count clock. It brings out twelve of its stages as divided-clock taps: the least significant stage, and every stage from the fourth to the last. The second and third stages stay internal. Each tap runs at the count clock rate divided by two raised to the stage number, so it acts as a bank of fixed frequency dividers for a time base.

The counter is a synchronous equivalent of a ripple chain. Every stage is a flop on the same falling edge, so all taps change together. A raised clear input forces the whole count to zero at once, without waiting for a clock edge. Release of the clear is retimed to the falling edge, so the first count after release always lands on a known edge.

A registered match output gives a spike-free decode of one count value. It is set when an advance lands on a chosen value, and it is built from a flop, never from combinational logic on the taps.

Top module: `tapcnt_top`

## Requirements
- R1: While `rst_i` is high, every bit of `tap_o` and `match_o` reads 0.
- R2: Once the clear has been released, each falling edge of `clk_i` increases the internal count by exactly one.
- R3: `tap_o[0]` is count bit 0 (stage 1). For k from 1 to 11, `tap_o[k]` is count bit k+2 (stage k+3). Count bits 1 and 2 are not brought out.
- R4: A rising `rst_i` clears the count and `match_o` at once, with no clock edge needed.
- R5: Between two falling edges of `clk_i`, and across a rising edge, `tap_o` and `match_o` hold their values.
- R6: After `rst_i` falls, the count stays 0 through the next two falling edges. It reaches 1 on the third falling edge.
- R7: From the all-ones count of 16383, the next falling edge gives 0.
- R8: The tap for stage n toggles once every 2^(n-1) falling edges. The stage-4 tap first goes high on the 8th advance after release, and the stage-14 tap on the 8192nd.
- R9: With `match_en_i` high, `match_o` is high during exactly the clock period in which the count equals `match_val_i`. The value and the enable are taken at the falling edge that produces that count, so right after a clear `match_o` is low even when the value is 0.
- R10: With `match_en_i` low at a falling edge, `match_o` is low in the following period, whatever `match_val_i` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Count clock; the falling edge advances the counter |
| rst_i | input | 1 | Active-high clear; asserts asynchronously, releases on the falling edge |
| match_en_i | input | 1 | Enables the registered match output |
| match_val_i | input | 14 | Count value to decode |
| tap_o | output | 12 | Stage 1, then stages 4 to 14, LSB first |
| match_o | output | 1 | High for the one period in which the count equals `match_val_i` |

## Verification
The bench builds the block with its default widths: a 14-stage count, the upper taps starting at stage 4, and a two-flop clear release. At these values, 16384 falling edges carry the counter through a full wrap. That lets the bench watch the last tap rise at 8192 and the count roll from 16383 to 0 within the run. The match test at the wrap uses value 0, which separates the cleared state from a count that was reached by advancing.

// File: rtl/tapcnt_pkg.sv
package tapcnt_pkg;

    localparam int unsigned CNT_W_DEF    = 14;
    localparam int unsigned HI_FIRST_DEF = 4;
    localparam int unsigned SYNC_N_DEF   = 2;

    // number of exposed taps: stage 1 plus stages hi_first..stages
    function automatic int unsigned tap_width(input int unsigned stages,
                                              input int unsigned hi_first);
        return stages - hi_first + 2;
    endfunction

    // count bit driving tap k
    function automatic int unsigned tap_bit(input int unsigned k,
                                            input int unsigned hi_first);
        return (k == 0) ? 0 : (hi_first - 2 + k);
    endfunction

    typedef enum logic [0:0] {
        MATCH_OFF = 1'b0,
        MATCH_ON  = 1'b1
    } match_mode_e;

endpackage

// File: rtl/tapcnt_clr_sync.sv
module tapcnt_clr_sync #(
    parameter int unsigned SYNC_N = tapcnt_pkg::SYNC_N_DEF
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic clr_o
);
    logic [SYNC_N-1:0] chain_q;

    // asserts at once, releases after SYNC_N falling edges
    always_ff @(negedge clk_i or posedge rst_i) begin
        if (rst_i) chain_q <= '1;
        else       chain_q <= {chain_q[SYNC_N-2:0], 1'b0};
    end

    assign clr_o = chain_q[SYNC_N-1];

    // R6: internal clear only drops after the raw clear has been low
    p_release_r6: assert property (@(negedge clk_i) disable iff (rst_i)
        $fell(clr_o) |-> $past(!rst_i));

endmodule

// File: rtl/tapcnt_core.sv
module tapcnt_core #(
    parameter int unsigned CNT_W = tapcnt_pkg::CNT_W_DEF
) (
    input  logic             clk_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nxt_o
);
    logic [CNT_W-1:0] cnt_q;

    // wraps naturally from all ones to zero
    assign cnt_nxt_o = cnt_q + 1'b1;

    always_ff @(negedge clk_i or posedge clr_i) begin
        if (clr_i) cnt_q <= '0;
        else       cnt_q <= cnt_nxt_o;
    end

    assign cnt_o = cnt_q;

    // R2, R7: one step per falling edge, modulo 2^CNT_W
    p_step_r2: assert property (@(negedge clk_i) disable iff (clr_i)
        !$past(clr_i) |-> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R4: a held clear keeps the count at zero
    p_clear_r4: assert property (@(negedge clk_i)
        clr_i |-> cnt_q == '0);

endmodule

// File: rtl/tapcnt_tap_sel.sv
module tapcnt_tap_sel #(
    parameter int unsigned CNT_W    = tapcnt_pkg::CNT_W_DEF,
    parameter int unsigned HI_FIRST = tapcnt_pkg::HI_FIRST_DEF,
    localparam int unsigned TAP_W   = tapcnt_pkg::tap_width(CNT_W, HI_FIRST)
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [TAP_W-1:0] tap_o
);
    for (genvar k = 0; k < TAP_W; k++) begin : g_tap
        assign tap_o[k] = cnt_i[tapcnt_pkg::tap_bit(k, HI_FIRST)];
    end

    if (HI_FIRST > 2) begin : g_hidden
        logic unused_hidden;
        assign unused_hidden = ^cnt_i[HI_FIRST-2:1];
    end

endmodule

// File: rtl/tapcnt_match.sv
module tapcnt_match #(
    parameter int unsigned CNT_W = tapcnt_pkg::CNT_W_DEF
) (
    input  logic             clk_i,
    input  logic             clr_i,
    input  tapcnt_pkg::match_mode_e mode_i,
    input  logic [CNT_W-1:0] val_i,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    output logic             match_o
);
    import tapcnt_pkg::*;

    logic hit_d, hit_q;

    // decode the value the count is about to take, register it
    always_comb begin
        hit_d = 1'b0;
        if (mode_i == MATCH_ON) hit_d = (cnt_nxt_i == val_i);
    end

    always_ff @(negedge clk_i or posedge clr_i) begin
        if (clr_i) hit_q <= 1'b0;
        else       hit_q <= hit_d;
    end

    assign match_o = hit_q;

    // R9: a hit lasts one period unless the compare value moved
    p_one_period_r9: assert property (@(negedge clk_i) disable iff (clr_i)
        hit_q |=> (!hit_q || !$stable(val_i)));

    // R10: disabled compare yields no hit
    p_disabled_r10: assert property (@(negedge clk_i) disable iff (clr_i)
        (mode_i == MATCH_OFF) |=> !hit_q);

endmodule

// File: rtl/tapcnt_top.sv
module tapcnt_top #(
    parameter int unsigned CNT_W    = tapcnt_pkg::CNT_W_DEF,
    parameter int unsigned HI_FIRST = tapcnt_pkg::HI_FIRST_DEF,
    parameter int unsigned SYNC_N   = tapcnt_pkg::SYNC_N_DEF,
    localparam int unsigned TAP_W   = tapcnt_pkg::tap_width(CNT_W, HI_FIRST)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             match_en_i,
    input  logic [CNT_W-1:0] match_val_i,
    output logic [TAP_W-1:0] tap_o,
    output logic             match_o
);
    import tapcnt_pkg::*;

    logic             clr;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    match_mode_e      mode;

    assign mode = match_en_i ? MATCH_ON : MATCH_OFF;

    tapcnt_clr_sync #(.SYNC_N(SYNC_N)) u_clr (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_o (clr)
    );

    tapcnt_core #(.CNT_W(CNT_W)) u_core (
        .clk_i     (clk_i),
        .clr_i     (clr),
        .cnt_o     (cnt),
        .cnt_nxt_o (cnt_nxt)
    );

    tapcnt_tap_sel #(.CNT_W(CNT_W), .HI_FIRST(HI_FIRST)) u_taps (
        .cnt_i (cnt),
        .tap_o (tap_o)
    );

    tapcnt_match #(.CNT_W(CNT_W)) u_match (
        .clk_i     (clk_i),
        .clr_i     (clr),
        .mode_i    (mode),
        .val_i     (match_val_i),
        .cnt_nxt_i (cnt_nxt),
        .match_o   (match_o)
    );

    // R1: raw clear held high means quiet outputs at the edge
    p_quiet_r1: assert property (@(negedge clk_i)
        rst_i |-> (tap_o == '0 && !match_o));

endmodule

// File: tb/tb_tapcnt_top.sv
module tb_tapcnt_top;

    logic        clk = 1'b1;
    logic        rst;
    logic        men;
    logic [13:0] mval;
    logic [11:0] tap;
    logic        match;

    int n_chk  = 0;
    int n_fail = 0;
    logic [13:0] ref_cnt;

    tapcnt_top dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .match_en_i  (men),
        .match_val_i (mval),
        .tap_o       (tap),
        .match_o     (match)
    );

    // 125 MHz: falls at 4, rises at 8, ...
    always #4 clk = ~clk;

    function automatic logic [11:0] exp_tap(input logic [13:0] c);
        return {c[13:3], c[0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // each posedge follows one falling edge; sample 1 ns later
    task automatic advance(input int n);
        repeat (n) @(posedge clk);
        #1;
        ref_cnt = ref_cnt + 14'(n);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        #1;
        ref_cnt = '0;
        check("R4 async clear taps", 32'(tap), 32'h0);
        check("R4 async clear match", 32'(match), 32'h0);
        advance(2);
        ref_cnt = '0;
        check("R1 taps in reset", 32'(tap), 32'h0);
        check("R1 match in reset", 32'(match), 32'h0);
        rst = 1'b0;
        advance(1);
        ref_cnt = '0;
        check("R6 first edge after release", 32'(tap), 32'h0);
        advance(1);
        ref_cnt = '0;
        check("R6 second edge after release", 32'(tap), 32'h0);
        advance(1);
        check("R6 third edge gives 1", 32'(tap), 32'(exp_tap(14'd1)));
    endtask

    task automatic t_count();
        do_reset();
        for (int i = 0; i < 40; i++) begin
            advance(1);
            check("R2 R3 step", 32'(tap), 32'(exp_tap(ref_cnt)));
        end
        advance(1000);
        check("R2 R3 long run", 32'(tap), 32'(exp_tap(ref_cnt)));
    endtask

    task automatic t_hold();
        logic [11:0] t0;
        logic        m0;
        t0 = tap;
        m0 = match;
        #2;
        check("R5 hold taps mid period", 32'(tap), 32'(t0));
        check("R5 hold match mid period", 32'(match), 32'(m0));
        @(posedge clk);
        #1;
        ref_cnt = ref_cnt + 1;
        check("R5 rising edge is not a count", 32'(tap), 32'(exp_tap(ref_cnt)));
    endtask

    task automatic t_divide();
        do_reset();
        advance(6);
        check("R8 stage4 low at 7", 32'(tap[1]), 32'h0);
        advance(1);
        check("R8 stage4 high at 8", 32'(tap[1]), 32'h1);
        advance(8191 - 8);
        check("R8 stage14 low at 8191", 32'(tap[11]), 32'h0);
        advance(1);
        check("R8 stage14 high at 8192", 32'(tap[11]), 32'h1);
    endtask

    task automatic t_wrap();
        // count is 8192 here
        advance(16383 - 8192);
        check("R7 all ones", 32'(tap), 32'hFFF);
        men  = 1'b1;
        mval = 14'd0;
        advance(1);
        check("R7 wrap to zero", 32'(tap), 32'h0);
        check("R9 match at wrapped zero", 32'(match), 32'h1);
        advance(1);
        check("R9 match lasts one period", 32'(match), 32'h0);
        men = 1'b0;
    endtask

    task automatic t_match();
        do_reset();
        men  = 1'b1;
        mval = 14'd0;
        check("R9 no match right after clear", 32'(match), 32'h0);
        mval = 14'd6;
        for (int i = 0; i < 8; i++) begin
            advance(1);
            check("R9 match vs count", 32'(match), 32'(ref_cnt == mval));
        end
        men  = 1'b0;
        mval = ref_cnt + 14'd1;
        for (int i = 0; i < 3; i++) begin
            advance(1);
            check("R10 disabled compare", 32'(match), 32'h0);
        end
        mval = ref_cnt + 14'd1;
        advance(1);
        check("R10 disabled at exact value", 32'(match), 32'h0);
    endtask

    task automatic t_mid_clear();
        advance(5);
        rst = 1'b1;
        #1;
        ref_cnt = '0;
        check("R4 clear without clock edge", 32'(tap), 32'h0);
        rst = 1'b0;
        advance(2);
        ref_cnt = '0;
        advance(1);
        check("R6 restart after mid clear", 32'(tap), 32'(exp_tap(14'd1)));
    endtask

    initial begin
        rst     = 1'b1;
        men     = 1'b0;
        mval    = '0;
        ref_cnt = '0;
        @(posedge clk);
        #1;
        t_count();
        t_hold();
        t_divide();
        t_wrap();
        t_match();
        t_mid_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule